// File: doc/BRIEF.md
# Bang-Bang Fine Frequency Loop Controller

This block is the fine tuning loop of a duty-cycled all-digital PLL. After each burst the oscillator is stopped. A phase detector outside this block then reports one bit: whether the last counted oscillator edge landed after the reference edge that closed the burst (late) or before it (early). The controller turns that bit into a single up or down move of a 9-bit fine DAC code. It makes exactly one move per burst, on a one-cycle strobe from the coarse controller.

The loop stays idle until the coarse loop reports zero error. While idle, the fine code is frozen. When the coarse indication rises, the code is loaded with mid-scale and the step starts large. Each time the early/late decision reverses, the step is halved, down to one LSB. The loop is reported as locked once it is dithering at one LSB. If the coarse indication drops, the loop returns to idle and its step is restored to the initial value.

Top module: `fine_bb_loop`

## Requirements
- R1: After reset, fine_code is 256, step_size is 16, fine_lock is 0, and the loop is idle.
- R2: While coarse_ok is 0, burst_done strobes have no effect: fine_code and step_size keep their values.
- R3: On the first clock edge where coarse_ok is 1 and the loop is idle, the loop becomes active and loads fine_code=256 and step_size=16. A burst_done strobe in that same cycle is ignored.
- R4: While active, a burst_done strobe with edge_late=1 raises fine_code by the step, and edge_late=0 (early) lowers it by the step. The result appears one clock after the strobe. Without a strobe, fine_code holds.
- R5: The first decision after activation, and any decision with the same polarity as the previous one, leave step_size unchanged.
- R6: A decision whose polarity differs from the previous decision halves step_size, with a minimum of 1. The halved step is the one applied to that same move.
- R7: fine_code saturates at 511 when moving up and at 0 when moving down.
- R8: fine_lock is 1 exactly when step_size is 1 and the last four decisions form an alternating run. The run starts at the decision that brought the step to 1, or at any later decision. Two equal decisions in a row clear fine_lock.
- R9: On a clock edge where coarse_ok is 0, the loop becomes idle, step_size returns to 16 and fine_lock clears. fine_code keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_ok | input | 1 | Coarse loop reports zero error |
| burst_done | input | 1 | One-cycle strobe: an early/late decision is valid |
| edge_late | input | 1 | 1 = last oscillator edge came after the reference edge, 0 = before it |
| fine_code | output | 9 | Fine DAC code |
| step_size | output | 5 | Current step in LSBs (16, 8, 4, 2 or 1) |
| fine_lock | output | 1 | Fine loop dithering at one LSB |

## Verification
Every result is registered, so each output is due exactly one clock after the strobe or coarse_ok change that causes it. This covers the code move, the step halving, the lock flag, the mid-scale load and the return to idle. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which falls after the single rising edge that applies the update. A bench-side model, written from the requirements alone, steps through each directed case and a long pseudo-random decision sweep. That sweep also toggles coarse_ok.

// File: rtl/fine_bb_loop.sv
module fine_bb_loop #(
  parameter int CODE_W    = 9,
  parameter int STEP_INIT = 16,
  parameter int LOCK_RUN  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            coarse_ok,
  input  logic                            burst_done,
  input  logic                            edge_late,
  output logic [CODE_W-1:0]               fine_code,
  output logic [$clog2(STEP_INIT+1)-1:0]  step_size,
  output logic                            fine_lock
);
  localparam int STEP_W = $clog2(STEP_INIT+1);
  localparam int RUN_W  = $clog2(LOCK_RUN+1);
  localparam logic [CODE_W-1:0] MID       = CODE_W'(1 << (CODE_W-1));
  localparam logic [CODE_W-1:0] CMAX      = '1;
  localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_RST  = STEP_W'(STEP_INIT);
  localparam logic [RUN_W-1:0]  RUN_FULL  = RUN_W'(LOCK_RUN);

  logic             active, has_prev, prev_late;
  logic [RUN_W-1:0] run;

  logic              flip;
  logic [STEP_W-1:0] step_nx;
  logic [CODE_W:0]   step_ext, sum_up;
  logic [CODE_W-1:0] code_up, code_dn;
  logic [RUN_W-1:0]  run_nx;

  assign flip     = has_prev && (edge_late != prev_late);
  assign step_nx  = (flip && step_size > STEP_ONE) ? (step_size >> 1) : step_size;
  assign step_ext = (CODE_W+1)'(step_nx);
  assign sum_up   = {1'b0, fine_code} + step_ext;
  assign code_up  = sum_up[CODE_W] ? CMAX : sum_up[CODE_W-1:0];
  assign code_dn  = ({1'b0, fine_code} < step_ext) ? '0 : fine_code - step_ext[CODE_W-1:0];

  always_comb begin
    if (step_nx != STEP_ONE)         run_nx = '0;
    else if (flip && run != '0)      run_nx = (run == RUN_FULL) ? RUN_FULL : run + 1'b1;
    else                             run_nx = RUN_W'(1);
  end

  assign fine_lock = active && (run == RUN_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      fine_code <= MID;
      step_size <= STEP_RST;
      has_prev  <= 1'b0;
      prev_late <= 1'b0;
      run       <= '0;
    end else if (!coarse_ok) begin
      active    <= 1'b0;
      step_size <= STEP_RST;
      has_prev  <= 1'b0;
      run       <= '0;
    end else if (!active) begin
      active    <= 1'b1;
      fine_code <= MID;
      step_size <= STEP_RST;
      has_prev  <= 1'b0;
      run       <= '0;
    end else if (burst_done) begin
      fine_code <= edge_late ? code_up : code_dn;
      step_size <= step_nx;
      has_prev  <= 1'b1;
      prev_late <= edge_late;
      run       <= run_nx;
    end
  end
endmodule

module fine_bb_loop_chk #(
  parameter int CODE_W    = 9,
  parameter int STEP_INIT = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            coarse_ok,
  input logic                            burst_done,
  input logic [CODE_W-1:0]               fine_code,
  input logic [$clog2(STEP_INIT+1)-1:0]  step_size,
  input logic                            fine_lock
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W-1));

  // R2
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_ok |=> $stable(fine_code));

  // R9
  drop_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_ok |=> (!fine_lock && step_size == STEP_INIT));

  // R4
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_ok && !burst_done) |=> ($stable(fine_code) || fine_code == MID));

  // R6
  step_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_size) == 1);

  // R8
  lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |-> step_size == 1);
endmodule

bind fine_bb_loop fine_bb_loop_chk #(.CODE_W(CODE_W), .STEP_INIT(STEP_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .coarse_ok(coarse_ok), .burst_done(burst_done),
  .fine_code(fine_code), .step_size(step_size), .fine_lock(fine_lock));

// File: tb/fine_bb_loop_tb.sv
module fine_bb_loop_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coarse_ok = 1'b0;
  logic       burst_done = 1'b0;
  logic       edge_late = 1'b0;
  logic [8:0] fine_code;
  logic [4:0] step_size;
  logic       fine_lock;

  int checks = 0;
  int failures = 0;

  int m_code = 256, m_step = 16, m_run = 0;
  bit m_act = 0, m_has = 0, m_prev = 0;

  always #5 clk = ~clk;

  fine_bb_loop u_dut (
    .clk(clk), .rst_n(rst_n), .coarse_ok(coarse_ok), .burst_done(burst_done),
    .edge_late(edge_late), .fine_code(fine_code), .step_size(step_size),
    .fine_lock(fine_lock));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "fine_code", int'(fine_code), m_code);
    chk(req, "step_size", int'(step_size), m_step);
    chk(req, "fine_lock", int'(fine_lock), int'(m_act && m_step == 1 && m_run >= 4));
  endtask

  task automatic set_coarse(bit v, string req);
    @(negedge clk);
    coarse_ok = v;
    @(negedge clk);
    if (!v) begin
      m_act = 0; m_step = 16; m_has = 0; m_run = 0;
    end else if (!m_act) begin
      m_act = 1; m_code = 256; m_step = 16; m_has = 0; m_run = 0;
    end
    chk_all(req);
  endtask

  task automatic burst(bit late, string req);
    bit flip;
    @(negedge clk);
    burst_done = 1'b1;
    edge_late = late;
    @(negedge clk);
    burst_done = 1'b0;
    if (coarse_ok && m_act) begin
      flip = m_has && (late != m_prev);
      if (flip && m_step > 1) m_step = m_step / 2;
      if (late) m_code = (m_code + m_step > 511) ? 511 : m_code + m_step;
      else      m_code = (m_code < m_step) ? 0 : m_code - m_step;
      if (m_step != 1) m_run = 0;
      else if (flip && m_run != 0) m_run = (m_run >= 4) ? 4 : m_run + 1;
      else m_run = 1;
      m_has = 1; m_prev = late;
    end
    chk_all(req);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    for (int i = 0; i < 4; i++) burst(i[0], "R2");
    // strobe in the enabling cycle is ignored
    @(negedge clk);
    coarse_ok = 1'b1; burst_done = 1'b1; edge_late = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
    m_act = 1; m_code = 256; m_step = 16;
    chk_all("R3");
    for (int i = 0; i < 20; i++) burst(1'b1, "R7_R5");
    chk("R7", "top clamp", int'(fine_code), 511);
    burst(1'b0, "R6");
    chk("R6", "halved step", int'(step_size), 8);
    burst(1'b0, "R5");
    for (int i = 0; i < 10; i++) burst(i[0], "R6_R8");
    chk("R8", "lock after alternation", int'(fine_lock), 1);
    burst(1'b1, "R8");
    burst(1'b1, "R8");
    chk("R8", "repeat clears lock", int'(fine_lock), 0);
    for (int i = 0; i < 4; i++) burst(i[0], "R8");
    set_coarse(1'b0, "R9");
    for (int i = 0; i < 3; i++) burst(1'b0, "R9_R2");
    set_coarse(1'b1, "R3");
    for (int i = 0; i < 20; i++) burst(1'b0, "R7");
    chk("R7", "bottom clamp", int'(fine_code), 0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 97 == 50) set_coarse(1'b0, "R9");
      if (i % 97 == 53) set_coarse(1'b1, "R3");
      if (lfsr[3]) burst(lfsr[0], "R4");
      else begin
        @(negedge clk);
        chk_all("R4");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule